// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. A clock enable that pulses sixteen times per bit period (the oversampling ratio is a parameter) paces all line sampling. The word length, whether a parity bit is present, the parity rule and the stop-bit selection come in as configuration inputs. The receiver captures them when it accepts a start bit.

Each finished character goes into a holding register together with parity, framing and overrun flags and a full flag. A one-cycle strobe marks every character that is loaded, and interrupt logic can use it. A read acknowledge from the bus side empties the holding register's status.

The control path is one state machine:
- RX_IDLE goes to RX_START on a tick that sees the line low.
- RX_START returns to RX_IDLE at mid-bit if the line is high again. Otherwise it goes to RX_DATA.
- RX_DATA goes to RX_PARITY after the last data bit when parity is enabled, and to RX_STOP when it is not.
- RX_PARITY goes to RX_STOP.
- RX_STOP finishes the character at the first stop bit's midpoint when a single stop bit is in force. It then goes to RX_IDLE, or to RX_MARK if that stop bit was low. With more than one stop bit, RX_STOP goes to RX_EXTRA.
- RX_EXTRA waits out the remaining stop time, finishes the character, then goes to RX_IDLE, or to RX_MARK on a framing error.
- RX_MARK holds until the line is seen high, then goes to RX_IDLE.

Top module: `async_rx_core`

## Requirements
- R1: While reset is asserted and after its release, the data register reads 0x00 and the full, parity, framing, overrun and strobe outputs are all 0.
- R2: A start is detected on a tick with the line low. The line is sampled again at the middle of the start bit, and if it is high no character is received and no strobe is produced.
- R3: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives least significant bit first, and data-register bits above the word length read 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_mode` 0 checks odd and 1 checks even, counting data plus parity ones. Modes 2 and 3 (fixed one or fixed zero) are never flagged. The parity bit is never stored.
- R5: With `cfg_stop2`=0 one stop bit is used. With `cfg_stop2`=1 the stop time is 1.5 bits for 5 data bits without parity, 1 bit for 8 data bits with parity, and 2 bits otherwise. The strobe and flags update at the middle of the last full stop bit, or at the middle of the trailing half bit for 1.5.
- R6: A low level at the middle of the first stop bit sets the framing flag together with full. Each character is judged on its own.
- R7: If a character completes while full is set and no read acknowledge is given, the data register and parity/framing flags keep their old values, the new character is dropped and the overrun flag is set.
- R8: A read acknowledge clears full and the parity, framing and overrun flags. The data register is unchanged.
- R9: After a framing error the receiver ignores a line that stays low (a break) and starts looking for a new start bit only after the line has returned high.
- R10: `word_stb` is a one-cycle pulse issued exactly once for every character loaded into the data register, and never for a dropped character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Oversampling enable, OVS pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Word length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity rule: odd, even, fixed one, fixed zero |
| cfg_stop2 | input | 1 | Extended stop time select |
| rd_ack | input | 1 | Data register read acknowledge |
| data_q | output | 8 | Received character |
| full_q | output | 1 | Data register holds an unread character |
| perr_q | output | 1 | Parity error |
| ferr_q | output | 1 | Framing error |
| ovr_q | output | 1 | Overrun |
| word_stb | output | 1 | Character loaded pulse |

## Verification
The hardest case to reach from the ports is a break. The line is held low past the stop bit, a character flagged with a framing error comes out, and the receiver then stays quiet while the line remains low. To get there, the stimulus holds the line low for several character times and acknowledges the one break character while the line is still low. Any further strobe then shows up as an unexpected word in the scoreboard. A narrow false-start pulse and an unread character followed by a second one cover the other two paths that must not produce a strobe.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_EXTRA,
        RX_MARK
    } rx_state_t;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_kind_t;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        par_mode_t  par_mode;
        logic       stop2;
    } rx_cfg_t;

    // Resolve the stop time from the frame shape.
    function automatic stop_kind_t stop_kind(rx_cfg_t c);
        stop_kind_t k;
        if (!c.stop2)
            k = STOP_ONE;
        else if (c.wlen == 2'd0 && !c.par_en)
            k = STOP_ONE_HALF;
        else if (c.wlen == 2'd3 && c.par_en)
            k = STOP_ONE;
        else
            k = STOP_TWO;
        return k;
    endfunction

    // Index of the last data bit (4..7).
    function automatic logic [2:0] last_bit(logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe <= '1;
        else
            pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
    import async_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  rx_cfg_t    cfg_in,
    output logic [1:0] wlen_q,
    output logic       par_en_q,
    output par_mode_t  par_mode_q,
    output logic       clr,
    output logic       shift_en,
    output logic       par_smp,
    output logic       done,
    output logic       frame_bad
);
    localparam int CW        = $clog2(OVS);
    localparam int MID       = OVS / 2;
    localparam int WAIT_HALF = OVS / 2 + OVS / 4;
    localparam int WAIT_TWO  = OVS;

    rx_state_t  state, nxt;
    rx_cfg_t    cfg_q;
    logic [CW-1:0] cnt;
    logic [2:0] bit_idx;
    logic       fe_r;
    stop_kind_t kind;
    logic       mid_tick, last_tick, extra_last;
    logic [CW-1:0] extra_lim;

    assign kind       = stop_kind(cfg_q);
    assign extra_lim  = (kind == STOP_ONE_HALF) ? CW'(WAIT_HALF - 1) : CW'(WAIT_TWO - 1);
    assign mid_tick   = tick && (cnt == CW'(MID - 1));
    assign last_tick  = tick && (cnt == CW'(OVS - 1));
    assign extra_last = tick && (cnt == extra_lim);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RX_IDLE;
        else
            state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rx) nxt = RX_START;
            RX_START:  if (mid_tick) nxt = rx ? RX_IDLE : RX_DATA;
            RX_DATA:   if (last_tick && bit_idx == last_bit(cfg_q.wlen))
                           nxt = cfg_q.par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (last_tick) nxt = RX_STOP;
            RX_STOP:   if (last_tick) begin
                           if (kind != STOP_ONE) nxt = RX_EXTRA;
                           else                  nxt = rx ? RX_IDLE : RX_MARK;
                       end
            RX_EXTRA:  if (extra_last) nxt = fe_r ? RX_MARK : RX_IDLE;
            RX_MARK:   if (rx) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    // Bit counters, captured configuration and stop sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            fe_r    <= 1'b0;
            cfg_q   <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (tick && !rx) cnt <= CW'(1);
                end
                RX_START: begin
                    if (tick) cnt <= mid_tick ? '0 : cnt + CW'(1);
                    if (mid_tick) begin
                        cfg_q   <= cfg_in;
                        bit_idx <= '0;
                    end
                end
                RX_DATA: begin
                    if (tick) cnt <= last_tick ? '0 : cnt + CW'(1);
                    if (last_tick) bit_idx <= bit_idx + 3'd1;
                end
                RX_PARITY: begin
                    if (tick) cnt <= last_tick ? '0 : cnt + CW'(1);
                end
                RX_STOP: begin
                    if (tick) cnt <= last_tick ? '0 : cnt + CW'(1);
                    if (last_tick) fe_r <= !rx;
                end
                RX_EXTRA: begin
                    if (tick) cnt <= cnt + CW'(1);
                end
                RX_MARK: cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        clr       = (state == RX_START) && mid_tick && !rx;
        shift_en  = (state == RX_DATA) && last_tick;
        par_smp   = (state == RX_PARITY) && last_tick;
        done      = ((state == RX_STOP) && last_tick && (kind == STOP_ONE)) ||
                    ((state == RX_EXTRA) && extra_last);
        frame_bad = (state == RX_STOP) ? !rx : fe_r;
    end

    assign wlen_q     = cfg_q.wlen;
    assign par_en_q   = cfg_q.par_en;
    assign par_mode_q = cfg_q.par_mode;
endmodule

// File: rtl/async_rx_shift.sv
module async_rx_shift
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              par_smp,
    input  logic              rx,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  par_mode_t         par_mode,
    output logic [DATA_W-1:0] word,
    output logic              par_fail
);
    logic [DATA_W-1:0] sh;
    logic              par_bit;
    logic [2:0]        align;
    logic              ones_odd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            par_bit <= 1'b0;
        end else if (clr) begin
            sh      <= '0;
            par_bit <= 1'b0;
        end else begin
            if (shift_en) sh <= {rx, sh[DATA_W-1:1]};
            if (par_smp)  par_bit <= rx;
        end
    end

    // Bits enter at the top; short words are moved down to bit 0.
    assign align    = 3'd3 - {1'b0, wlen};
    assign word     = sh >> align;
    assign ones_odd = (^word) ^ par_bit;

    always_comb begin
        par_fail = 1'b0;
        if (par_en) begin
            unique case (par_mode)
                PAR_ODD:   par_fail = !ones_odd;
                PAR_EVEN:  par_fail = ones_odd;
                PAR_MARK:  par_fail = 1'b0;
                PAR_SPACE: par_fail = 1'b0;
                default:   par_fail = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    input  logic              par_fail,
    input  logic              frame_bad,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              perr_q,
    output logic              ferr_q,
    output logic              ovr_q,
    output logic              stb
);
    logic load;

    assign load = done && (!full_q || rd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            stb    <= 1'b0;
        end else begin
            stb <= load;
            if (load) begin
                data_q <= word;
                full_q <= 1'b1;
                perr_q <= par_fail;
                ferr_q <= frame_bad;
                ovr_q  <= 1'b0;
            end else if (done) begin
                ovr_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop2,
    input  logic       rd_ack,
    output logic [7:0] data_q,
    output logic       full_q,
    output logic       perr_q,
    output logic       ferr_q,
    output logic       ovr_q,
    output logic       word_stb
);
    logic       rx_s;
    rx_cfg_t    cfg;
    logic [1:0] wlen_q;
    logic       par_en_q;
    par_mode_t  par_mode_q;
    logic       clr, shift_en, par_smp, done, frame_bad, par_fail;
    logic [DATA_W-1:0] word;

    assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en,
                   par_mode: par_mode_t'(cfg_par_mode), stop2: cfg_stop2};

    async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    async_rx_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s), .cfg_in(cfg),
        .wlen_q(wlen_q), .par_en_q(par_en_q), .par_mode_q(par_mode_q),
        .clr(clr), .shift_en(shift_en), .par_smp(par_smp),
        .done(done), .frame_bad(frame_bad)
    );

    async_rx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .par_smp(par_smp), .rx(rx_s), .wlen(wlen_q), .par_en(par_en_q),
        .par_mode(par_mode_q), .word(word), .par_fail(par_fail)
    );

    async_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .done(done), .word(word),
        .par_fail(par_fail), .frame_bad(frame_bad), .rd(rd_ack),
        .data_q(data_q), .full_q(full_q), .perr_q(perr_q),
        .ferr_q(ferr_q), .ovr_q(ovr_q), .stb(word_stb)
    );
endmodule

// File: rtl/async_rx_core_chk.sv
module async_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_ack,
    input logic [7:0] data_q,
    input logic       full_q,
    input logic       perr_q,
    input logic       ferr_q,
    input logic       ovr_q,
    input logic       word_stb
);
    p_errs_need_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_q || ferr_q) |-> full_q);

    p_ovr_need_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> full_q);

    p_unread_data_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !rd_ack) |=> $stable(data_q));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (!ovr_q && (full_q == word_stb)));

    p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    p_stb_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> (full_q && !ovr_q));
endmodule

bind async_rx_core async_rx_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .data_q(data_q),
    .full_q(full_q), .perr_q(perr_q), .ferr_q(ferr_q), .ovr_q(ovr_q),
    .word_stb(word_stb)
);

// File: tb/async_rx_core_tb.sv
module async_rx_core_tb;
    localparam int BITC = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = '0;
    logic       tick16;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] data_q;
    logic       full_q, perr_q, ferr_q, ovr_q, word_stb;

    int cyc = 0;
    int errs = 0;
    int checks = 0;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        int         due;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tdiv <= tdiv + 2'd1;
    end
    assign tick16 = (tdiv == 2'd3);

    async_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_stop2(cfg_stop2),
        .rd_ack(rd_ack), .data_q(data_q), .full_q(full_q),
        .perr_q(perr_q), .ferr_q(ferr_q), .ovr_q(ovr_q),
        .word_stb(word_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every load strobe.
    always @(negedge clk) begin
        if (rst_n && word_stb) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected word strobe", int'(data_q), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(data_q == e.d, "R3", "data", int'(data_q), int'(e.d));
                check(perr_q == e.pe, "R4", "parity flag", int'(perr_q), int'(e.pe));
                check(ferr_q == e.fe, "R6", "framing flag", int'(ferr_q), int'(e.fe));
                check((cyc - e.due) >= -8 && (cyc - e.due) <= 8, "R5",
                      "strobe cycle", cyc, e.due);
            end
        end
    end

    task automatic bits(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // Driver: send one frame with the current configuration.
    task automatic send(input logic [7:0] d, input bit bad_par,
                        input bit bad_stop, input bit expect_word);
        int nb, t0, stop_len, off;
        logic p;
        logic [7:0] dm;
        exp_t e;
        nb = 5 + int'(cfg_wlen);
        dm = d & 8'((1 << nb) - 1);
        unique case (cfg_par_mode)
            2'd0: p = ~^dm;
            2'd1: p = ^dm;
            2'd2: p = 1'b1;
            default: p = 1'b0;
        endcase
        if (bad_par) p = ~p;
        if (!cfg_stop2) begin
            stop_len = BITC; off = 32;
        end else if (cfg_wlen == 2'd0 && !cfg_par_en) begin
            stop_len = BITC + BITC / 2; off = 80;
        end else if (cfg_wlen == 2'd3 && cfg_par_en) begin
            stop_len = BITC; off = 32;
        end else begin
            stop_len = 2 * BITC; off = 96;
        end
        @(negedge clk);
        t0 = cyc;
        e.d   = dm;
        e.pe  = bad_par && cfg_par_en && (cfg_par_mode < 2'd2);
        e.fe  = bad_stop;
        e.due = t0 + (1 + nb + int'(cfg_par_en)) * BITC + off;
        if (expect_word) sb.push_back(e);
        bits(1'b0, BITC);
        for (int i = 0; i < nb; i++) bits(d[i], BITC);
        if (cfg_par_en) bits(p, BITC);
        if (bad_stop) begin
            bits(1'b0, BITC);
            bits(1'b1, stop_len - BITC + 32);
        end else begin
            bits(1'b1, stop_len + 32);
        end
    endtask

    task automatic read_reg();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic pe,
                           input logic [1:0] pm, input logic s2);
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_mode = pm; cfg_stop2 = s2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        // R1 during reset
        check({data_q, full_q, perr_q, ferr_q, ovr_q, word_stb} == '0, "R1",
              "outputs in reset", int'(data_q), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check({data_q, full_q, perr_q, ferr_q, ovr_q, word_stb} == '0, "R1",
              "outputs after reset", int'(full_q), 0);

        // 8N1 basic frames
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0);
        send(8'hA5, 0, 0, 1);
        check(full_q == 1'b1, "R10", "full after word", int'(full_q), 1);
        read_reg();
        check(full_q == 1'b0, "R8", "full cleared by read", int'(full_q), 0);
        check(data_q == 8'hA5, "R8", "data kept after read", int'(data_q), 8'hA5);
        send(8'h3C, 0, 0, 1);
        read_reg();

        // R2 false start: 12 clocks low
        @(negedge clk);
        bits(1'b0, 12);
        bits(1'b1, 400);
        check(full_q == 1'b0, "R2", "no word after false start", int'(full_q), 0);
        send(8'h81, 0, 0, 1);
        read_reg();

        // 7 bits even parity, two stop bits
        set_cfg(2'd2, 1'b1, 2'd1, 1'b1);
        send(8'hD5, 0, 0, 1);
        read_reg();
        send(8'h12, 1, 0, 1);
        check(perr_q == 1'b1, "R4", "even parity error held", int'(perr_q), 1);
        read_reg();
        check(perr_q == 1'b0, "R8", "parity flag cleared", int'(perr_q), 0);

        // 7 bits odd parity
        set_cfg(2'd2, 1'b1, 2'd0, 1'b0);
        send(8'h2B, 0, 0, 1);
        read_reg();
        send(8'h2B, 1, 0, 1);
        read_reg();

        // fixed-one parity with a wrong bit is not flagged (R4)
        set_cfg(2'd3, 1'b1, 2'd2, 1'b0);
        send(8'h6E, 1, 0, 1);
        read_reg();

        // 5 bits, no parity, 1.5 stop bits (R5)
        set_cfg(2'd0, 1'b0, 2'd0, 1'b1);
        send(8'hF5, 0, 0, 1);
        check(data_q == 8'h15, "R3", "upper bits zero for 5-bit word", int'(data_q), 8'h15);
        read_reg();

        // 8 bits with parity and stop select set: single stop (R5)
        set_cfg(2'd3, 1'b1, 2'd0, 1'b1);
        send(8'h96, 0, 0, 1);
        read_reg();

        // 6 bits even parity
        set_cfg(2'd1, 1'b1, 2'd1, 1'b0);
        send(8'hEA, 0, 0, 1);
        read_reg();

        // R6 framing error, then a clean word
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0);
        send(8'h44, 0, 1, 1);
        check(ferr_q == 1'b1, "R6", "framing flag held", int'(ferr_q), 1);
        read_reg();
        check(ferr_q == 1'b0, "R8", "framing flag cleared", int'(ferr_q), 0);
        send(8'h45, 0, 0, 1);
        read_reg();

        // R7 overrun
        send(8'h11, 0, 0, 1);
        send(8'h22, 0, 0, 0);
        check(data_q == 8'h11, "R7", "old data kept", int'(data_q), 8'h11);
        check(ovr_q == 1'b1, "R7", "overrun flag", int'(ovr_q), 1);
        check(full_q == 1'b1, "R7", "still full", int'(full_q), 1);
        read_reg();
        check(ovr_q == 1'b0 && full_q == 1'b0, "R8", "overrun cleared",
              int'(ovr_q), 0);

        // R9 break: line low for several character times
        begin
            exp_t e;
            @(negedge clk);
            e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1;
            e.due = cyc + 9 * BITC + 32;
            sb.push_back(e);
            rxd = 1'b0;
            repeat (800) @(negedge clk);
            read_reg();
            repeat (1800) @(negedge clk);
            check(full_q == 1'b0, "R9", "no word during break", int'(full_q), 0);
            bits(1'b1, 200);
        end
        send(8'h5A, 0, 0, 1);
        read_reg();

        repeat (50) @(negedge clk);
        check(sb.size() == 0, "R10", "all expected words seen", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule